// File: doc/BRIEF.md
# I2C Target Ten-Bit Address Recognizer

This block is the bus-facing front end of an I2C target that answers only to a ten-bit address. It oversamples SCL and SDA with the system clock and finds START, repeated START and STOP conditions. It checks the two-byte address sequence against a configured ten-bit own address. It acknowledges by enabling an open-drain pull-down on SDA. Once addressed, it exchanges data bytes with local logic through a small byte handshake.

Addressing has two steps. The header byte carries a fixed five-bit pattern, the two top address bits and a direction bit, and every target that shares those top bits may acknowledge it. A second byte carrying the low eight bits then picks out a single target, which becomes an addressed receiver. The target remembers this state. A later repeated START with a read header alone turns it into a transmitter, with no second address byte. A STOP, or a repeated START followed by an address that does not match, ends the addressed state.

Top module: `i2c10_target`

## Requirements
- R1: A STOP clears `addressed` and `is_tx`. A START begins a new address phase from any state.
- R2: A header byte of binary 11110, then own_addr[9:8], then direction bit 0, is acknowledged and raises a one-cycle `addr_event`. No `rx_valid` is raised for it.
- R3: After an acknowledged write header, the next byte must equal own_addr[7:0]. On a match it is acknowledged, `addressed` becomes 1 and `is_tx` stays 0. On a mismatch it is not acknowledged and `addressed` becomes 0.
- R4: As a receiver, each data byte is taken MSB first and acknowledged. It appears on `rx_data` with a one-cycle `rx_valid`.
- R5: If the target is addressed, a repeated START followed by the header with direction bit 1 is acknowledged. `is_tx` then becomes 1 and `tx_load` pulses. The byte on `tx_data` is then sent MSB first.
- R6: If the target is not addressed, a header with direction bit 1 is not acknowledged, and the target stays unaddressed.
- R7: A first byte that lacks the 11110 prefix, or whose top address bits differ, is not acknowledged and clears `addressed`. Later bytes are ignored until the next START.
- R8: As a transmitter, a controller ACK loads and sends the next byte. A controller NACK releases SDA, and no further byte is loaded or driven until START or STOP.
- R9: `sda_oe` changes only while the synchronized SCL is low, apart from release on START or STOP. An acknowledge holds SDA low for the whole ninth clock, and SDA is released right after it.
- R10: After a repeated START, a matching write header followed by a matching low byte keeps `addressed` at 1. A low byte that does not match clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 10 | Ten-bit address this target answers to |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| addressed | output | 1 | Target fully addressed since the last STOP |
| is_tx | output | 1 | Addressed as transmitter |
| addr_event | output | 1 | One-cycle pulse when a header byte is acknowledged |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_data | input | 8 | Next byte to transmit, sampled on `tx_load` |
| tx_load | output | 1 | One-cycle pulse when `tx_data` is captured |

## Verification
The assertions assume a well-behaved controller. SCL stays in each phase for many system clocks, so SDA from the controller moves only while SCL is low, except when it forms START or STOP. `own_addr` also holds steady during a transfer. The bench's bus model changes SDA only in the low half of each SCL period and waits ten system clocks per quarter bit. It keeps `own_addr` fixed and never issues START or STOP while the target holds SDA low. Under these conditions, every change of the output enable falls within a low SCL phase.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR1,
    ST_ADDR2,
    ST_ACK,
    ST_RXB,
    ST_TXB,
    ST_TXACK,
    ST_WAIT
  } tgt_state_t;

  localparam logic [4:0] TEN_BIT_PREFIX = 5'b11110;
endpackage

// File: rtl/i2c10_line_cond.sv
module i2c10_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] scl_q, sda_q;
  logic         scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[TOP-1:0], scl_i};
      sda_q <= {sda_q[TOP-1:0], sda_i};
      scl_p <= scl_q[TOP];
      sda_p <= sda_q[TOP];
    end
  end

  assign scl_s    = scl_q[TOP];
  assign sda_s    = sda_q[TOP];
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match
  import i2c10_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [DATA_W-1:0] rx_byte,
  output logic              hdr_hit,
  output logic              lo_hit,
  output logic              rw
);
  localparam int HI_W = ADDR_W - DATA_W;

  assign hdr_hit = (rx_byte[DATA_W-1 -: 5] == TEN_BIT_PREFIX) &&
                   (rx_byte[HI_W:1] == own_addr[ADDR_W-1 -: HI_W]);
  assign lo_hit  = (rx_byte == own_addr[DATA_W-1:0]);
  assign rw      = rx_byte[0];
endmodule

// File: rtl/i2c10_target.sv
module i2c10_target
  import i2c10_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              addressed,
  output logic              is_tx,
  output logic              addr_event,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_load
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);

  logic scl_s, sda_s, start_ev, stop_ev, scl_rise, scl_fall;
  logic hdr_hit, lo_hit, rw;

  tgt_state_t        state, next_st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic              nine, mack, byte_full;

  i2c10_line_cond #(.STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2c10_addr_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
    .own_addr(own_addr), .rx_byte(shreg),
    .hdr_hit(hdr_hit), .lo_hit(lo_hit), .rw(rw)
  );

  assign byte_full = (cnt == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      next_st    <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      nine       <= 1'b0;
      mack       <= 1'b0;
      sda_oe     <= 1'b0;
      addressed  <= 1'b0;
      is_tx      <= 1'b0;
      addr_event <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      tx_load    <= 1'b0;
    end else begin
      addr_event <= 1'b0;
      rx_valid   <= 1'b0;
      tx_load    <= 1'b0;
      if (stop_ev) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        nine      <= 1'b0;
        addressed <= 1'b0;
        is_tx     <= 1'b0;
      end else if (start_ev) begin
        state  <= ST_ADDR1;
        cnt    <= '0;
        sda_oe <= 1'b0;
        nine   <= 1'b0;
      end else begin
        case (state)
          ST_ADDR1, ST_ADDR2, ST_RXB: begin
            if (scl_rise) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && byte_full) begin
              cnt <= '0;
              if (state == ST_ADDR1) begin
                if (hdr_hit && !rw) begin
                  sda_oe     <= 1'b1;
                  addr_event <= 1'b1;
                  is_tx      <= 1'b0;
                  next_st    <= ST_ADDR2;
                  state      <= ST_ACK;
                end else if (hdr_hit && rw && addressed) begin
                  sda_oe     <= 1'b1;
                  addr_event <= 1'b1;
                  is_tx      <= 1'b1;
                  next_st    <= ST_TXB;
                  state      <= ST_ACK;
                end else begin
                  addressed <= 1'b0;
                  is_tx     <= 1'b0;
                  state     <= ST_IDLE;
                end
              end else if (state == ST_ADDR2) begin
                if (lo_hit) begin
                  sda_oe    <= 1'b1;
                  addressed <= 1'b1;
                  is_tx     <= 1'b0;
                  next_st   <= ST_RXB;
                  state     <= ST_ACK;
                end else begin
                  addressed <= 1'b0;
                  is_tx     <= 1'b0;
                  state     <= ST_IDLE;
                end
              end else begin
                rx_data  <= shreg;
                rx_valid <= 1'b1;
                sda_oe   <= 1'b1;
                next_st  <= ST_RXB;
                state    <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_rise) begin
              nine <= 1'b1;
            end else if (scl_fall && nine) begin
              nine  <= 1'b0;
              cnt   <= '0;
              state <= next_st;
              if (next_st == ST_TXB) begin
                shreg   <= tx_data;
                tx_load <= 1'b1;
                sda_oe  <= ~tx_data[DATA_W-1];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_TXB: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (byte_full) begin
                cnt    <= '0;
                sda_oe <= 1'b0;
                state  <= ST_TXACK;
              end else begin
                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                sda_oe <= ~shreg[DATA_W-2];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              nine <= 1'b1;
              mack <= ~sda_s;
            end else if (scl_fall && nine) begin
              nine <= 1'b0;
              if (mack) begin
                shreg   <= tx_data;
                tx_load <= 1'b1;
                sda_oe  <= ~tx_data[DATA_W-1];
                cnt     <= '0;
                state   <= ST_TXB;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c10_target_chk.sv
module i2c10_target_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_oe,
  input logic addressed,
  input logic is_tx,
  input logic addr_event,
  input logic rx_valid,
  input logic tx_load
);
  // R9: the enable moves only in a low SCL phase, or on release at START or STOP
  a_r9_oe_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(start_ev) || $past(stop_ev)));

  // R1: a STOP leaves the target unaddressed
  a_r1_stop_clears: assert property (@(posedge clk) disable iff (rst)
    $past(stop_ev) |-> (!addressed && !is_tx));

  // R5: transmitter mode only exists inside an addressed session
  a_r5_tx_needs_addr: assert property (@(posedge clk) disable iff (rst)
    is_tx |-> addressed);

  // R4: received bytes are delivered only to an addressed receiver
  a_r4_rx_when_recv: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (addressed && !is_tx));

  // R4: the receive strobe lasts one cycle
  a_r4_rx_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R8: bytes are loaded only as a transmitter
  a_r8_load_when_tx: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> is_tx);

  // R2: header events, receive strobes and loads never coincide
  a_r2_events_apart: assert property (@(posedge clk) disable iff (rst)
    $onehot0({addr_event, rx_valid, tx_load}));
endmodule

bind i2c10_target i2c10_target_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_ev(start_ev), .stop_ev(stop_ev),
  .sda_oe(sda_oe), .addressed(addressed), .is_tx(is_tx),
  .addr_event(addr_event), .rx_valid(rx_valid), .tx_load(tx_load)
);

// File: tb/i2c10_target_tb_top.sv
module i2c10_target_tb_top;
  localparam int CLK_NS = 10;
  localparam int Q      = 10;
  localparam logic [9:0] OWN = 10'h2A5;
  localparam logic [7:0] HDR_W = 8'hF4;
  localparam logic [7:0] HDR_R = 8'hF5;
  // {low address byte, data byte, expected ack of low byte}
  localparam logic [16:0] VEC [6] = '{
    {8'hA5, 8'h3C, 1'b1}, {8'hA4, 8'h00, 1'b0}, {8'hA5, 8'hFF, 1'b1},
    {8'h25, 8'h00, 1'b0}, {8'hA5, 8'h81, 1'b1}, {8'hA5, 8'h00, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe, addressed, is_tx, addr_event, rx_valid, tx_load;
  logic [7:0] rx_data;
  logic [7:0] tx_data = 8'h00;

  int n_tests = 0;
  int n_fail  = 0;
  int rx_cnt  = 0;
  int tx_cnt  = 0;
  int ev_cnt  = 0;
  logic [7:0] last_rx = 8'h00;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c10_target dut_i (
    .clk(clk), .rst(rst), .own_addr(OWN), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .addressed(addressed), .is_tx(is_tx),
    .addr_event(addr_event), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_load(tx_load)
  );

  always @(negedge clk) begin
    if (rx_valid) begin rx_cnt++; last_rx = rx_data; end
    if (tx_load) tx_cnt++;
    if (addr_event) ev_cnt++;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q/2);
    ack = ~sda_bus;
    wt(Q/2); scl = 1'b0; wt(Q);
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q/2); b[i] = sda_bus; wt(Q/2); scl = 1'b0;
    end
    sda_m = ~give_ack; wt(Q); scl = 1'b1; wt(Q); scl = 1'b0; wt(Q);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    int rx0, ev0, tx0;
    wt(5); rst = 1'b0; wt(5);
    // R1: reset state
    chk(sda_oe == 0 && addressed == 0 && is_tx == 0 && rx_valid == 0, "R1", "reset outputs",
        {sda_oe, addressed, is_tx, rx_valid}, 0);

    // Table walk: write header, low byte, one data byte, STOP
    for (int i = 0; i < 6; i++) begin
      logic [7:0] lo, dat;
      logic exp_ack;
      {lo, dat, exp_ack} = VEC[i];
      bus_start();
      ev0 = ev_cnt; rx0 = rx_cnt;
      wr_byte(HDR_W, ack);
      chk(ack == 1'b1, "R2", "header ack", ack, 1);
      chk(ev_cnt == ev0 + 1 && rx_cnt == rx0, "R2", "event without rx", ev_cnt - ev0, 1);
      wr_byte(lo, ack);
      chk(ack == exp_ack, "R3", "low byte ack", ack, exp_ack);
      chk(addressed == exp_ack && is_tx == 0, "R3", "addressed", addressed, exp_ack);
      chk(sda_oe == 0, "R9", "release after ack", sda_oe, 0);
      if (exp_ack) begin
        wr_byte(dat, ack);
        chk(ack == 1'b1, "R4", "data ack", ack, 1);
        chk(rx_cnt == rx0 + 1 && last_rx == dat, "R4", "rx byte", last_rx, dat);
      end
      bus_stop(); wt(4);
      chk(addressed == 0 && is_tx == 0, "R1", "stop clears", addressed, 0);
    end

    // R5 / R8: read session after repeated START
    tx_data = 8'hC3;
    bus_start(); wr_byte(HDR_W, ack); wr_byte(8'hA5, ack);
    tx0 = tx_cnt;
    bus_start(); wr_byte(HDR_R, ack);
    chk(ack == 1'b1, "R5", "read header ack", ack, 1);
    chk(is_tx == 1 && addressed == 1, "R5", "transmitter mode", is_tx, 1);
    chk(tx_cnt == tx0 + 1, "R5", "first load", tx_cnt - tx0, 1);
    tx_data = 8'h5A;
    rd_byte(1'b1, rb);
    chk(rb == 8'hC3, "R5", "first tx byte", rb, 8'hC3);
    rd_byte(1'b0, rb);
    chk(rb == 8'h5A, "R8", "byte after controller ack", rb, 8'h5A);
    chk(tx_cnt == tx0 + 2 && sda_oe == 0, "R8", "nack releases", tx_cnt - tx0, 2);
    rd_byte(1'b0, rb);
    chk(rb == 8'hFF && tx_cnt == tx0 + 2, "R8", "silent after nack", rb, 8'hFF);
    bus_stop(); wt(4);
    chk(addressed == 0 && is_tx == 0, "R1", "stop ends read", is_tx, 0);

    // R6: read header with no earlier addressing
    bus_start(); wr_byte(HDR_R, ack);
    chk(ack == 1'b0 && addressed == 0, "R6", "unaddressed read header", ack, 0);
    bus_stop();

    // R7: foreign prefix, then a following byte is ignored
    rx0 = rx_cnt;
    bus_start(); wr_byte(8'hA4, ack);
    chk(ack == 1'b0, "R7", "foreign prefix nack", ack, 0);
    wr_byte(8'hA5, ack);
    chk(ack == 1'b0 && rx_cnt == rx0 && addressed == 0, "R7", "ignored byte", ack, 0);
    // R7: top bits differ after being addressed
    bus_start(); wr_byte(HDR_W, ack); wr_byte(8'hA5, ack);
    bus_start(); wr_byte(8'hF0, ack);
    chk(ack == 1'b0 && addressed == 0, "R7", "top bits mismatch clears", addressed, 0);
    bus_stop();

    // R10: repeated START with matching then mismatching address
    bus_start(); wr_byte(HDR_W, ack); wr_byte(8'hA5, ack);
    bus_start(); wr_byte(HDR_W, ack); wr_byte(8'hA5, ack);
    chk(ack == 1'b1 && addressed == 1, "R10", "re-address kept", addressed, 1);
    rx0 = rx_cnt;
    wr_byte(8'h77, ack);
    chk(rx_cnt == rx0 + 1 && last_rx == 8'h77, "R10", "rx after re-address", last_rx, 8'h77);
    bus_start(); wr_byte(HDR_W, ack); wr_byte(8'h11, ack);
    chk(ack == 1'b0 && addressed == 0, "R10", "different low byte clears", addressed, 0);
    bus_stop(); wt(10);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule